// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

The block takes bytes from a host and sends each one as an asynchronous serial character on `txd`. A character is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts `cfg_div + 1` clock cycles, so the bit rate is the clock rate divided by that factor. Between characters the line rests high.

The host writes bytes over a valid/ready port. One holding buffer sits in front of an output shift register, so the host can queue the next byte while the current one is still on the line. Sending is gated: a character may start only while `tx_en` is high and the active-low `cts_n` is low. The write port is ready only under that permission and only when the holding buffer is empty, so `wr_ready` can serve directly as an interrupt request.

Back-pressure rules: a byte is taken on a rising clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low the host keeps `wr_data` steady and the block ignores `wr_valid`. `tx_empty` is a plain status pin that shows the shift register is idle. The frame format and the bit length are captured when a byte enters the shift register.

Top module: `cts_uart_tx`

## Requirements
- R1: Out of reset `txd` is 1, `tx_empty` is 1 and the holding buffer is empty.
- R2: `wr_ready` equals (holding buffer empty) AND `tx_en` AND NOT `cts_n`. A byte is accepted on an edge with `wr_valid` and `wr_ready` both high. `wr_valid` while `wr_ready` is low is ignored and later causes no character.
- R3: When the shifter is idle and sending is permitted, an accepted byte moves into the shifter on the next edge. From that edge `txd` is 0 (start bit), `tx_empty` is 0, and `wr_ready` is 1 again while permission holds.
- R4: After the start bit, `txd` carries `5 + cfg_len` data bits (`cfg_len` 0..3 selects 5..8), least significant bit first. Data bits above the configured length are never sent.
- R5: With `cfg_par_en` = 1, a parity bit follows the data bits. It is computed over the configured data bits only. With `cfg_par_odd` = 0 the count of ones in data plus parity is even; with `cfg_par_odd` = 1 it is odd. With `cfg_par_en` = 0 no parity bit is sent.
- R6: The character ends with one high stop bit when `cfg_stop2` = 0 and with two when `cfg_stop2` = 1.
- R7: Every bit of a character, including the start and stop bits, is held on `txd` for exactly `cfg_div + 1` clock cycles.
- R8: If the holding buffer is full and sending is permitted when the last stop bit ends, the next start bit begins on that same edge, with no idle cycle.
- R9: If `cts_n` goes high or `tx_en` goes low, a character already on the line completes. No new character starts while permission is absent. A buffered byte waits and starts on the first edge at which permission is present again.
- R10: `tx_empty` is 1 exactly when no character is on the line. It rises, and `txd` returns high, on the edge that ends the last stop bit, unless R8 applies.
- R11: Format and bit-length inputs are sampled when a byte enters the shifter. Changing them during a character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, a multiple of the baud rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | Holding buffer empty and sending permitted |
| wr_data | input | 8 | Byte to send |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_div | input | DIV_W | Clocks per bit minus one |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output, high when idle |
| tx_empty | output | 1 | Output shift register idle |

## Verification
A byte accepted at edge k puts the start bit on `txd` from edge k+1, when `tx_empty` also falls and `wr_ready` comes back. Bit b of the character then occupies the `cfg_div + 1` cycles that follow edge k+1+b·(cfg_div+1). The line goes idle at the edge after the final stop cycle, or the next start bit appears there for a queued byte. The bench drives inputs and samples outputs on falling edges. It counts exactly that many falling edges from the acceptance edge before each comparison. It compares every cycle of every bit against an expected bit that it computes itself from the data and format, so a bit that is early, late or wrong by a single cycle is caught.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W  = 8;
  localparam int LEN_W   = 2;
  localparam int MIN_LEN = 5;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             par_en;
    logic             par_odd;
    logic             stop2;
  } fmt_t;

  // Full character image, bit 0 goes out first; unused tail stays high.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                     input fmt_t f);
    logic [FRAME_W-1:0] img;
    logic               par;
    int                 nbits;
    img   = '1;
    img[0] = 1'b0;
    nbits = MIN_LEN + int'(f.len);
    par   = f.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        img[i+1] = d[i];
        par      = par ^ d[i];
      end
    end
    if (f.par_en) img[nbits+1] = par;
    return img;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input fmt_t f);
    int n;
    n = 1 + MIN_LEN + int'(f.len) + int'(f.par_en) + 1 + int'(f.stop2);
    return CNT_W'(n);
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         permit,
  input  logic         take,
  output logic         wr_ready,
  output logic         full,
  output logic [W-1:0] data
);

  assign wr_ready = ~full & permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

  // R2: an accepted byte is stored
  a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (full && data == $past(wr_data)));

  // R9: a waiting byte stays put until the shifter takes it
  a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data)));

endmodule

// File: rtl/uart_tx_pacer.sv
module uart_tx_pacer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run & (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= tick ? '0 : cnt + 1'b1;
    else              cnt <= '0;
  end

  // R7: with a factor above one, bit boundaries never come on adjacent cycles
  a_r7_no_double_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && div != '0) |=> !tick);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              permit,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  fmt_t              fmt,
  input  logic [DIV_W-1:0]  div,
  output logic              load,
  output logic              busy,
  output logic              txd,
  output logic [DIV_W-1:0]  div_q
);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   left;
  logic               last;

  assign last = (left == CNT_W'(1));
  assign load = permit & buf_full & (~busy | (tick & last));
  assign txd  = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sh    <= '1;
      left  <= '0;
      div_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      sh    <= build_frame(buf_data, fmt);
      left  <= frame_len(fmt);
      div_q <= div;
    end else if (busy && tick) begin
      if (last) begin
        busy <= 1'b0;
        sh   <= '1;
        left <= '0;
      end else begin
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        left <= left - 1'b1;
      end
    end
  end

  // R7: between bit boundaries the line does not move
  a_r7_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));

  // R3: every load opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !txd));

  // R1: an idle shifter rests the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

endmodule

// File: rtl/cts_uart_tx.sv
module cts_uart_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_en,
  input  logic              cts_n,
  output logic              txd,
  output logic              tx_empty
);

  logic              permit;
  logic              take;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              busy;
  logic              tick;
  logic [DIV_W-1:0]  div_q;
  fmt_t              fmt;

  assign permit   = tx_en & ~cts_n;
  assign fmt      = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign tx_empty = ~busy;

  uart_tx_hold #(.W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .permit   (permit),
    .take     (take),
    .wr_ready (wr_ready),
    .full     (buf_full),
    .data     (buf_data)
  );

  uart_tx_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (take),
    .run     (busy),
    .div     (div_q),
    .tick    (tick)
  );

  uart_tx_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .permit   (permit),
    .buf_full (buf_full),
    .buf_data (buf_data),
    .fmt      (fmt),
    .div      (cfg_div),
    .load     (take),
    .busy     (busy),
    .txd      (txd),
    .div_q    (div_q)
  );

  // R9: a character only leaves idle under permission
  a_r9_start_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(tx_en && !cts_n));

  // R10: an empty shifter means a high line
  a_r10_empty_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

endmodule

// File: tb/cts_uart_tx_bench.sv
module cts_uart_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_valid = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [1:0]       cfg_len = 2'd3;
  logic             cfg_par_en = 1'b0;
  logic             cfg_par_odd = 1'b0;
  logic             cfg_stop2 = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic             tx_en = 1'b1;
  logic             cts_n = 1'b0;
  logic             wr_ready;
  logic             txd;
  logic             tx_empty;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cts_uart_tx #(.DIV_W(DIV_W)) u_cts_uart_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .cfg_div(cfg_div),
    .tx_en(tx_en), .cts_n(cts_n), .txd(txd), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(input logic [7:0] d, input int len, input bit pe,
                                 input bit po, input int b);
    int nb;
    int ones;
    nb = 5 + len;
    if (b == 0) return 1'b0;
    if (b <= nb) return d[b-1];
    if (pe && b == nb + 1) begin
      ones = 0;
      for (int i = 0; i < nb; i++) ones += int'(d[i]);
      return bit'(ones % 2) ^ po;
    end
    return 1'b1;
  endfunction

  function automatic string bit_tag(input int len, input bit pe, input int b, input string stag);
    if (b == 0) return stag;
    if (b <= 5 + len) return "R4";
    if (pe && b == 6 + len) return "R5";
    return "R6";
  endfunction

  // Samples from the next falling edge: bits in order, each div+1 cycles (R7).
  task automatic check_frame(input logic [7:0] d, input int len, input bit pe, input bit po,
                             input bit st2, input int div, input string stag);
    int nframe;
    nframe = 1 + 5 + len + int'(pe) + 1 + int'(st2);
    for (int b = 0; b < nframe; b++) begin
      bit e;
      bit bad;
      int act;
      e = exp_bit(d, len, pe, po, b);
      bad = 1'b0;
      act = int'(e);
      for (int j = 0; j <= div; j++) begin
        @(negedge clk);
        if (b == 0 && j == 0) begin
          chk(tx_empty == 1'b0, "R10", int'(tx_empty), 0);
          chk(wr_ready == 1'b1, "R3", int'(wr_ready), 1);
        end
        if (txd !== e && !bad) begin
          bad = 1'b1;
          act = int'(txd);
        end
      end
      chk(!bad, (div == 0) ? bit_tag(len, pe, b, stag) : "R7", act, int'(e));
    end
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    chk(txd == 1'b1 && tx_empty == 1'b1, tag, int'({txd, tx_empty}), 3);
  endtask

  task automatic put(input logic [7:0] d);
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic hold_idle(input int n, input string tag);
    bit bad;
    bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_empty !== 1'b1) bad = 1'b1;
    end
    chk(!bad, tag, int'(bad), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hB4; pats[1] = 8'h6B; pats[2] = 8'hFF; pats[3] = 8'h00;

    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1", int'(txd), 1);
    chk(tx_empty == 1'b1, "R1", int'(tx_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R1", int'(wr_ready), 1);

    // Sweep of format, factor and data (R4 R5 R6 R7 R10)
    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
          for (int dv = 0; dv < 3; dv += 2)
            for (int p = 0; p < 4; p++) begin
              cfg_len = 2'(len);
              cfg_par_en = (pm != 0);
              cfg_par_odd = (pm == 2);
              cfg_stop2 = st[0];
              cfg_div = DIV_W'(dv);
              put(pats[p]);
              chk(txd == 1'b1 && tx_empty == 1'b1, "R3", int'({txd, tx_empty}), 3);
              check_frame(pats[p], len, pm != 0, pm == 2, st[0], dv, "R3");
              check_idle("R10");
            end

    // Back-to-back (R8)
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0; cfg_div = DIV_W'(1);
    put(8'h5A);
    fork
      check_frame(8'h5A, 3, 1'b0, 1'b0, 1'b0, 1, "R3");
      begin
        repeat (3) @(negedge clk);
        chk(wr_ready == 1'b1, "R3", int'(wr_ready), 1);
        put(8'hC3);
        chk(wr_ready == 1'b0, "R2", int'(wr_ready), 0);
      end
    join
    check_frame(8'hC3, 3, 1'b0, 1'b0, 1'b0, 1, "R8");
    check_idle("R10");

    // Disabled writes are ignored (R2)
    tx_en = 1'b0;
    wr_data = 8'h55;
    wr_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(wr_ready == 1'b0, "R2", int'(wr_ready), 0);
    wr_valid = 1'b0;
    tx_en = 1'b1;
    hold_idle(20, "R2");
    chk(wr_ready == 1'b1, "R2", int'(wr_ready), 1);

    // CTS raised mid-character (R9)
    put(8'h96);
    fork
      check_frame(8'h96, 3, 1'b0, 1'b0, 1'b0, 1, "R3");
      begin
        repeat (2) @(negedge clk);
        put(8'h3E);
        repeat (2) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    hold_idle(20, "R9");
    chk(wr_ready == 1'b0, "R9", int'(wr_ready), 0);
    cts_n = 1'b0;
    check_frame(8'h3E, 3, 1'b0, 1'b0, 1'b0, 1, "R9");
    check_idle("R10");

    // Enable dropped between acceptance and start (R9)
    put(8'hA1);
    tx_en = 1'b0;
    hold_idle(10, "R9");
    tx_en = 1'b1;
    check_frame(8'hA1, 3, 1'b0, 1'b0, 1'b0, 1, "R9");
    check_idle("R10");

    // Format change during a character (R11)
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b1; cfg_div = DIV_W'(2);
    put(8'h71);
    fork
      check_frame(8'h71, 3, 1'b1, 1'b0, 1'b1, 2, "R11");
      begin
        repeat (4) @(negedge clk);
        cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_stop2 = 1'b0; cfg_div = '0;
      end
    join
    check_idle("R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule